// File: doc/BRIEF.md
# Multi-Mode Serial Flash Read Master

This block is the host side of a read path to a serial NOR flash. It sits on a four-line bidirectional data bus. A requester hands it a read mode, a 24-bit start address and a byte count. The block then runs one complete bus transaction. It lowers chip select and clocks out the command byte. It sends the address on one, two or four lines, as the mode requires. It idles the bus for the mode's dummy clocks and shifts the read data back in. Each assembled byte is returned on a one-cycle valid strobe.

The serial clock is a divided copy of the system clock, and the bus runs in SPI mode 0. The serial clock idles low. The master changes its outputs after a falling edge and samples on a rising edge. Each mode uses its own lane mapping, which the block packs and unpacks bit-exactly.

After the last requested byte, the block raises chip select and pulses `done`. It then keeps chip select high for a programmable minimum number of system clocks before it accepts the next request. A request with a zero byte count finishes at once and causes no bus activity.

Top module: `flash_rd_master`

## Requirements
- R1: After reset, csN is 1, sck is 0, every bit of dqOe is 0 and reqReady is 1.
- R2: Each transaction starts with an 8-clock command byte on DQ0, MSB first, with dqOe = 4'b0001. The mode code selects the command byte: 0 -> 03h, 1 -> 0Bh, 2 -> 3Bh, 3 -> BBh, 4 -> EBh. Codes 5 to 7 behave exactly like code 0.
- R3: The address follows the command, MSB first. Modes 0, 1 and 2 send it on DQ0 alone in 24 clocks. Mode 3 sends two bits per clock in 12 clocks, with DQ1 carrying the higher bit of each pair (A23 on DQ1 while A22 is on DQ0). Mode 4 sends a nibble per clock on DQ3..DQ0 in 6 clocks, starting with A23..A20. dqOe covers exactly the lanes in use.
- R4: The address is followed by 0, 8, 8, 4 or 6 dummy clocks for modes 0 to 4. dqOe is 0 on every lane from the falling edge that ends the address until chip select rises.
- R5: Read data is sampled on rising sck edges, MSB first. Modes 0 and 1 take one bit per clock from DQ1. Modes 2 and 3 take a bit pair per clock, with DQ1 carrying the higher bit. Mode 4 takes a nibble per clock from DQ3..DQ0, high nibble first.
- R6: sck is low whenever csN is high. Its period is 2*DIV_HALF system clocks, and it toggles only while csN is low.
- R7: A request of N > 0 bytes yields exactly N rdValid strobes, for consecutive flash addresses starting at reqAddr. csN then rises, and done pulses high for a single cycle after the last byte.
- R8: reqReady is high only while the block is idle. A request is taken only in a cycle where reqValid and reqReady are both high, and reqReady stays low during a transaction.
- R9: A request with reqLen = 0 produces a done pulse without csN ever going low.
- R10: Between two transactions csN stays high for at least csGap system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqMode | input | 3 | Read mode code (see R2) |
| reqAddr | input | 24 | Flash start address |
| reqLen | input | LEN_W | Number of bytes to read |
| csGap | input | GAP_W | Minimum chip-select high time in system clocks |
| rdData | output | 8 | Returned byte |
| rdValid | output | 1 | rdData valid for one cycle |
| done | output | 1 | One-cycle pulse at request completion |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| dqOut | output | 4 | Values driven onto DQ3..DQ0 |
| dqOe | output | 4 | Per-lane output enable for DQ3..DQ0 |
| dqIn | input | 4 | Values read from DQ3..DQ0 |

## Verification
The assertions take several things for granted about the inputs. The flash drives dqIn only during the data phase. csGap does not change while a transaction is running. The request fields are read only in the cycle the request is accepted. Under those assumptions, the properties about chip select, the serial clock idle level, bus release, and the single-cycle strobes have to hold whatever the data values are. The bench keeps within these limits in three ways. A bus model drives dqIn only after the falling edge that opens a data clock, and it computes each byte from its address. csGap is held constant for the whole run. Requests are presented only at falling system-clock edges, and reqValid is dropped as soon as reqReady has taken the request.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    LANE1 = 2'd0,
    LANE2 = 2'd1,
    LANE4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic [7:0] opcode;
    lane_e      addrLanes;
    logic [3:0] dummyClks;
    lane_e      dataLanes;
  } modeCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  loadCmd;
    logic  loadAddr;
    logic  shiftOut;
    logic  sampleIn;
    logic  drive;
    lane_e txLanes;
    lane_e rxLanes;
  } dpCtl_t;

  function automatic modeCfg_t decodeMode(input logic [2:0] mode);
    modeCfg_t c;
    case (mode)
      3'd1:    c = '{8'h0B, LANE1, 4'd8, LANE1};
      3'd2:    c = '{8'h3B, LANE1, 4'd8, LANE2};
      3'd3:    c = '{8'hBB, LANE2, 4'd4, LANE2};
      3'd4:    c = '{8'hEB, LANE4, 4'd6, LANE4};
      default: c = '{8'h03, LANE1, 4'd0, LANE1};
    endcase
    return c;
  endfunction

  function automatic logic [4:0] addrClocks(input lane_e l);
    case (l)
      LANE2:   return 5'd12;
      LANE4:   return 5'd6;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [3:0] laneMask(input lane_e l);
    case (l)
      LANE2:   return 4'b0011;
      LANE4:   return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/flash_rd_datapath.sv
module flash_rd_datapath
  import flash_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [7:0]  opcode,
  input  logic [23:0] addr,
  input  logic [3:0]  dqIn,
  output logic [3:0]  dqOut,
  output logic [3:0]  dqOe,
  output logic        byteEnd,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  logic [31:0] txShift;
  logic [7:0]  rxShift;
  logic [7:0]  rxNext;
  logic [2:0]  rxCnt;
  logic [2:0]  rxStep;

  always_comb begin
    case (ctl.rxLanes)
      LANE2: begin
        rxNext = {rxShift[5:0], dqIn[1], dqIn[0]};
        rxStep = 3'd2;
      end
      LANE4: begin
        rxNext = {rxShift[3:0], dqIn};
        rxStep = 3'd4;
      end
      default: begin
        rxNext = {rxShift[6:0], dqIn[1]};
        rxStep = 3'd1;
      end
    endcase
  end

  // the bit counter wraps to zero exactly when a byte is full
  assign byteEnd = ctl.sampleIn && (3'(rxCnt + rxStep) == 3'd0);

  always_comb begin
    case (ctl.txLanes)
      LANE2:   dqOut = {2'b00, txShift[31], txShift[30]};
      LANE4:   dqOut = txShift[31:28];
      default: dqOut = {3'b000, txShift[31]};
    endcase
    dqOe = ctl.drive ? laneMask(ctl.txLanes) : 4'b0000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxCnt   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= byteEnd;
      if (ctl.loadCmd) begin
        txShift <= {opcode, 24'h000000};
        rxCnt   <= '0;
      end else if (ctl.loadAddr) begin
        txShift <= {addr, 8'h00};
      end else if (ctl.shiftOut) begin
        case (ctl.txLanes)
          LANE2:   txShift <= {txShift[29:0], 2'b00};
          LANE4:   txShift <= {txShift[27:0], 4'h0};
          default: txShift <= {txShift[30:0], 1'b0};
        endcase
      end
      if (ctl.sampleIn) begin
        rxShift <= rxNext;
        rxCnt   <= 3'(rxCnt + rxStep);
      end
      if (byteEnd) rdData <= rxNext;
    end
  end

endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int LEN_W    = 16,
  parameter int GAP_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqMode,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [GAP_W-1:0] csGap,
  input  logic             byteEnd,
  output logic             reqReady,
  output logic             csN,
  output logic             sck,
  output logic             done,
  output dpCtl_t           ctl,
  output logic [7:0]       opcode,
  output logic [23:0]      addr
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_TAIL, ST_GAP
  } state_e;

  state_e           state;
  logic [DIV_W-1:0] divCnt;
  logic [4:0]       clkLeft;
  logic [LEN_W-1:0] byteLeft;
  logic [GAP_W-1:0] gapCnt;
  lane_e            aLanesR;
  lane_e            dLanesR;
  logic [3:0]       dummyR;
  modeCfg_t         reqCfg;
  logic             running, tick, riseEv, fallEv, lastClk;

  assign reqCfg   = decodeMode(reqMode);
  assign opcode   = reqCfg.opcode;
  assign reqReady = (state == ST_IDLE);
  assign running  = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DUMMY) ||
                    (state == ST_DATA) || (state == ST_TAIL);
  assign tick     = running && (divCnt == DIV_W'(DIV_HALF - 1));
  assign riseEv   = tick && !sck;
  assign fallEv   = tick && sck;
  assign lastClk  = (clkLeft == 5'd1);

  always_comb begin
    ctl.loadCmd  = (state == ST_IDLE) && reqValid && (reqLen != '0);
    ctl.loadAddr = fallEv && (state == ST_CMD) && lastClk;
    ctl.shiftOut = fallEv && ((state == ST_CMD) || (state == ST_ADDR)) && !lastClk;
    ctl.sampleIn = riseEv && (state == ST_DATA);
    ctl.drive    = (state == ST_CMD) || (state == ST_ADDR);
    ctl.txLanes  = (state == ST_ADDR) ? aLanesR : LANE1;
    ctl.rxLanes  = dLanesR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sck      <= 1'b0;
      divCnt   <= '0;
      clkLeft  <= '0;
      byteLeft <= '0;
      gapCnt   <= '0;
      done     <= 1'b0;
      aLanesR  <= LANE1;
      dLanesR  <= LANE1;
      dummyR   <= '0;
      addr     <= '0;
    end else begin
      done <= 1'b0;
      if (running) begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
        if (tick) sck <= ~sck;
      end
      case (state)
        ST_IDLE: if (reqValid) begin
          aLanesR  <= reqCfg.addrLanes;
          dLanesR  <= reqCfg.dataLanes;
          dummyR   <= reqCfg.dummyClks;
          addr     <= reqAddr;
          byteLeft <= reqLen;
          divCnt   <= '0;
          if (reqLen == '0) begin
            done   <= 1'b1;
            gapCnt <= '0;
            state  <= ST_GAP;
          end else begin
            csN     <= 1'b0;
            clkLeft <= 5'd8;
            state   <= ST_CMD;
          end
        end
        ST_CMD: if (fallEv) begin
          if (lastClk) begin
            clkLeft <= addrClocks(aLanesR);
            state   <= ST_ADDR;
          end else clkLeft <= clkLeft - 5'd1;
        end
        ST_ADDR: if (fallEv) begin
          if (lastClk) begin
            if (dummyR == 4'd0) state <= ST_DATA;
            else begin
              clkLeft <= {1'b0, dummyR};
              state   <= ST_DUMMY;
            end
          end else clkLeft <= clkLeft - 5'd1;
        end
        ST_DUMMY: if (fallEv) begin
          if (lastClk) state <= ST_DATA;
          else clkLeft <= clkLeft - 5'd1;
        end
        ST_DATA: if (byteEnd) begin
          byteLeft <= byteLeft - LEN_W'(1);
          if (byteLeft == LEN_W'(1)) state <= ST_TAIL;
        end
        ST_TAIL: if (fallEv) begin
          csN    <= 1'b1;
          done   <= 1'b1;
          gapCnt <= csGap;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          if (gapCnt <= GAP_W'(1)) state <= ST_IDLE;
          else gapCnt <= gapCnt - GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_rd_master.sv
module flash_rd_master
  import flash_rd_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int LEN_W    = 16,
  parameter int GAP_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqMode,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [GAP_W-1:0] csGap,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             done,
  output logic             csN,
  output logic             sck,
  output logic [3:0]       dqOut,
  output logic [3:0]       dqOe,
  input  logic [3:0]       dqIn
);

  dpCtl_t      ctl;
  logic [7:0]  opcode;
  logic [23:0] addr;
  logic        byteEnd;

  flash_rd_ctrl #(
    .DIV_HALF(DIV_HALF), .LEN_W(LEN_W), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqAddr(reqAddr), .reqLen(reqLen), .csGap(csGap), .byteEnd(byteEnd),
    .reqReady(reqReady), .csN(csN), .sck(sck), .done(done), .ctl(ctl),
    .opcode(opcode), .addr(addr)
  );

  flash_rd_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opcode(opcode), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .byteEnd(byteEnd),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/flash_rd_checker.sv
module flash_rd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic [3:0] dqOe,
  input logic       reqReady,
  input logic       rdValid,
  input logic       done
);

  a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  a_r6_sck_moves_selected: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sck) |-> !$past(csN));

  a_r4_bus_released_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (dqOe == 4'b0000));

  a_r4_no_drive_with_data: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (dqOe == 4'b0000));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_byte_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !$past(csN));

  a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  a_r2_lane0_only_or_wider: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (dqOe == 4'b0001));

endmodule

bind flash_rd_master flash_rd_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .dqOe(dqOe),
  .reqReady(reqReady), .rdValid(rdValid), .done(done)
);

// File: tb/sim_flash_rd_master.sv
`timescale 1ns/1ps
module sim_flash_rd_master;

  localparam int DIV_HALF = 2;
  localparam int GAP      = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqMode = '0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic [7:0]  csGap = 8'(GAP);
  logic [7:0]  rdData;
  logic        rdValid, done, csN, sck;
  logic [3:0]  dqOut, dqOe;
  logic [3:0]  dqIn = 4'h0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_rd_master #(.DIV_HALF(DIV_HALF), .LEN_W(16), .GAP_W(8)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqAddr(reqAddr), .reqLen(reqLen), .csGap(csGap),
    .rdData(rdData), .rdValid(rdValid), .done(done), .csN(csN), .sck(sck),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  // mode code, start address, byte count
  localparam logic [42:0] VEC [7] = '{
    {3'd0, 24'h000100, 16'd5},
    {3'd1, 24'h123456, 16'd3},
    {3'd2, 24'hABCDEF, 16'd4},
    {3'd3, 24'h5A5A5A, 16'd6},
    {3'd4, 24'hC3C3C0, 16'd7},
    {3'd4, 24'hFFFFFE, 16'd4},
    {3'd7, 24'h000010, 16'd2}
  };

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] expOp(input logic [2:0] m);
    case (m)
      3'd1:    return 8'h0B;
      3'd2:    return 8'h3B;
      3'd3:    return 8'hBB;
      3'd4:    return 8'hEB;
      default: return 8'h03;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash bus model
  int       clkNum = 0;
  logic [7:0]  mOp = '0;
  logic [23:0] mAddr = '0;
  int       aL = 1, dum = 0, dL = 1, dStart = 32;
  int       oeErr = 0;
  time      lastRise = 0, minPer = 1000000, maxPer = 0;

  always @(posedge sck or posedge csN) begin
    if (csN) clkNum = 0;
    else begin
      if (clkNum > 0) begin
        if ($time - lastRise < minPer) minPer = $time - lastRise;
        if ($time - lastRise > maxPer) maxPer = $time - lastRise;
      end
      lastRise = $time;
      if (clkNum < 8) begin
        mOp = {mOp[6:0], dqOut[0]};
        if (dqOe != 4'b0001) oeErr++;
        if (clkNum == 7) begin
          case (mOp)
            8'h0B:   begin aL = 1; dum = 8; dL = 1; end
            8'h3B:   begin aL = 1; dum = 8; dL = 2; end
            8'hBB:   begin aL = 2; dum = 4; dL = 2; end
            8'hEB:   begin aL = 4; dum = 6; dL = 4; end
            default: begin aL = 1; dum = 0; dL = 1; end
          endcase
          dStart = 8 + 24 / aL + dum;
        end
      end else if (clkNum < 8 + 24 / aL) begin
        case (aL)
          2: begin
            mAddr = {mAddr[21:0], dqOut[1:0]};
            if (dqOe != 4'b0011) oeErr++;
          end
          4: begin
            mAddr = {mAddr[19:0], dqOut};
            if (dqOe != 4'b1111) oeErr++;
          end
          default: begin
            mAddr = {mAddr[22:0], dqOut[0]};
            if (dqOe != 4'b0001) oeErr++;
          end
        endcase
      end else if (dqOe != 4'b0000) oeErr++;
      clkNum++;
    end
  end

  always @(negedge sck) begin
    if (!csN && clkNum >= dStart) begin
      int k, cpb, w;
      logic [7:0] b;
      k = clkNum - dStart;
      cpb = 8 / dL;
      w = k % cpb;
      b = memByte(mAddr + 24'(k / cpb));
      case (dL)
        2:       dqIn = {2'b00, b[7-2*w], b[6-2*w]};
        4:       dqIn = (w == 0) ? b[7:4] : b[3:0];
        default: dqIn = {2'b00, b[7-w], 1'b0};
      endcase
    end
  end

  // output monitor
  logic [7:0] rxBuf [0:255];
  int rxCount = 0, doneCount = 0, cyc = 0, lastValidCyc = 0, doneCyc = 0;
  int csFalls = 0, csRun = 0, minGap = 1000000;
  logic prevCs = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rdValid) begin
      rxBuf[rxCount % 256] = rdData;
      rxCount++;
      lastValidCyc = cyc;
    end
    if (done) begin
      doneCount++;
      doneCyc = cyc;
    end
    if (csN) csRun++;
    else begin
      if (csRun > 0 && csRun < minGap) minGap = csRun;
      csRun = 0;
    end
    if (prevCs && !csN) csFalls++;
    prevCs = csN;
  end

  task automatic doReq(input logic [2:0] m, input logic [23:0] a, input logic [15:0] n);
    int guard = 0;
    @(negedge clk);
    while (!reqReady && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    reqMode  = m;
    reqAddr  = a;
    reqLen   = n;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input int startDone);
    int guard = 0;
    while (doneCount == startDone && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (doneCount == startDone) check(1'b0, "R7", "done never seen", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 1'b1, "R1", "csN in reset", csN, 1);
    check(sck == 1'b0, "R1", "sck in reset", sck, 0);
    check(dqOe == 4'h0, "R1", "dqOe in reset", dqOe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);

    for (int i = 0; i < 7; i++) begin
      logic [2:0]  m;
      logic [23:0] a;
      logic [15:0] n;
      int rx0, dn0, oe0, bad;
      logic [7:0] badAct, badExp;
      m = VEC[i][42:40];
      a = VEC[i][39:16];
      n = VEC[i][15:0];
      rx0 = rxCount;
      dn0 = doneCount;
      oe0 = oeErr;
      doReq(m, a, n);
      check(reqReady == 1'b0, "R8", "reqReady while busy", reqReady, 0);
      waitDone(dn0);
      @(negedge clk);
      check(mOp == expOp(m), "R2", "command byte", mOp, expOp(m));
      check(mAddr == a, "R3", "address", mAddr, a);
      check(oeErr == oe0, "R4", "lane enables wrong (count)", oeErr - oe0, 0);
      check(rxCount - rx0 == int'(n), "R7", "byte count", rxCount - rx0, n);
      bad = 0;
      badAct = '0;
      badExp = '0;
      for (int j = 0; j < int'(n) && j < rxCount - rx0; j++) begin
        if (bad == 0 && rxBuf[(rx0 + j) % 256] != memByte(a + 24'(j))) begin
          bad = 1;
          badAct = rxBuf[(rx0 + j) % 256];
          badExp = memByte(a + 24'(j));
        end
      end
      check(bad == 0, "R5", "read data", badAct, badExp);
      check(doneCyc > lastValidCyc, "R7", "done after last byte", doneCyc, lastValidCyc + 1);
    end

    // R6 serial clock period and R10 chip-select gap after back-to-back requests
    check(minPer == time'(2 * DIV_HALF * 20), "R6", "min sck period", minPer, 2 * DIV_HALF * 20);
    check(maxPer == time'(2 * DIV_HALF * 20), "R6", "max sck period", maxPer, 2 * DIV_HALF * 20);
    check(minGap >= GAP, "R10", "min csN high cycles", minGap, GAP);

    // R9 zero-length request
    begin
      int f0, d0;
      f0 = csFalls;
      d0 = doneCount;
      doReq(3'd4, 24'h001234, 16'd0);
      waitDone(d0);
      repeat (4) @(negedge clk);
      check(doneCount == d0 + 1, "R9", "done pulses", doneCount - d0, 1);
      check(csFalls == f0, "R9", "csN falls", csFalls - f0, 0);
      check(reqReady == 1'b1, "R8", "ready after zero request", reqReady, 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule